// File: doc/BRIEF.md
# PC Card ATA Host Address Decoder

This block sits behind the host side of a removable storage card. It watches the host address, the two card-enable lines, the register-select line and the four access strobes. From these it works out which task-file register is being accessed, whether the access is a 16-bit word or a single byte, and which half of the data bus carries the byte.

Five addressing modes are supported, chosen by a static mode input:

- memory mapped;
- sixteen contiguous registers in I/O space;
- the primary I/O window;
- the secondary I/O window;
- the disk-drive (True IDE) arrangement.

The outputs are registered. They are a register index, a one-cycle read pulse and a one-cycle write pulse, a word flag, a high-lane flag and two lane drive enables for the data pads. The task-file registers and the pads themselves belong to neighbouring logic.

Top module: `ata_host_decode`

## Requirements
- R1: The mode input selects the window: 0 memory mapped, 1 contiguous I/O, 2 primary I/O, 3 secondary I/O, 4 disk-drive arrangement. Codes 5 to 7 never select anything. Mode 0 accepts only reg_n high with oe_n (read) or we_n (write). Modes 1 to 4 accept only reg_n low with iord_n (read) or iowr_n (write). Any other strobe combination is not an access.
- R2: With both card enables low (ce1_n=0, ce2_n=0), the access is a 16-bit word on both lanes, and it is accepted only for the data register. In modes 0 and 1 that is offset 0h/1h or 8h/9h. In modes 2 and 3 it is base+0/+1. In all other places nothing is selected.
- R3: With ce1_n=0 and ce2_n=1, the access is a byte on the low lane. Address bit 0 picks the even or the odd register of the pair.
- R4: With ce1_n=1 and ce2_n=0 (outside mode 4), the odd register of the pair is accessed on the high lane, whatever address bit 0 is.
- R5: Offsets map to the index as follows. Offsets 0h to 7h give index 0 to 7: data, error/features, sector count, sector number, cylinder low, cylinder high, drive/head, status/command. Offsets 8h and 9h give index 0, the duplicate data. Dh gives index 1, Eh gives index 8 (alternate status / device control) and Fh gives index 9 (drive address). Ah to Ch select nothing. A read and a write at the same index reach different registers; the direction is told apart by tf_rd and tf_wr.
- R6: In modes 0 and 1, only A3:A0 is decoded. A10:A4 have no effect.
- R7: Modes 2 and 3 decode A9:A0 against 1F0h–1F7h plus 3F6h–3F7h (mode 2), or 170h–177h plus 376h–377h (mode 3). The eight-register block gives offsets 0h–7h and the control pair gives Eh–Fh. A10 is ignored, and any address outside these windows selects nothing.
- R8: In mode 4, only A2:A0 is decoded. ce1_n=0 with ce2_n=1 reaches the command block, where offset 0 is a 16-bit data access and every other offset is a low-lane byte. ce1_n=1 with ce2_n=0 reaches the control block, where offset 6 gives index 8 and offset 7 gives index 9, both on the low lane; the other offsets give nothing. Both enables high, or both low, give nothing.
- R9: The drive address register (index 9) is read-only. A write to it produces no select, no write pulse and no drive.
- R10: tf_sel, tf_idx, word_acc, hi_lane and the drive enables show the access sampled at the previous clock edge. tf_rd and tf_wr are high only in the first such cycle of an access. The drive enables are set only for reads: drv_lo_en for word or low-lane reads, and drv_hi_en for word or high-lane reads.
- R11: When the read and write strobes of the active family are asserted together, nothing is selected.
- R12: While rst_n is low at a clock edge, every output is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Static addressing mode code |
| host_addr | input | 11 | Host address A10:A0 |
| ce1_n | input | 1 | Card enable for the even byte, active low |
| ce2_n | input | 1 | Card enable for the odd byte, active low |
| reg_n | input | 1 | Register/attribute select, active low |
| oe_n | input | 1 | Memory read strobe, active low |
| we_n | input | 1 | Memory write strobe, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| tf_sel | output | 1 | A qualified access is in progress |
| tf_idx | output | 4 | Task-file register index |
| tf_rd | output | 1 | One-cycle read pulse |
| tf_wr | output | 1 | One-cycle write pulse |
| word_acc | output | 1 | Access is a 16-bit word |
| hi_lane | output | 1 | Byte access uses D15:D8 |
| drv_lo_en | output | 1 | Drive D7:D0 toward the host |
| drv_hi_en | output | 1 | Drive D15:D8 toward the host |

## Verification
Two things can land in the same cycle and fight over the same select. The first is a read strobe with a write strobe. The bench forces this by holding both strobes of one family low across every mode, enable pattern and address, and expects no select and no pulse. The second is a write aimed at the read-only drive address, which shares its slot with a readable register. The address sweep issues reads and writes at that slot with identical address and enables. It judges that only the read yields a select with the expected lane drive, while the write leaves every output low.

// File: rtl/ata_dec_pkg.sv
// Shared definitions for the host address decoder: mode codes,
// card-enable access kinds and task-file index values.
// Assumes the mode input is static while accesses are made.
package ata_dec_pkg;

    localparam int MODE_W = 3;
    localparam int OFF_W  = 4;
    localparam int IDX_W  = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_MEM    = 3'd0,
        MODE_CONTIG = 3'd1,
        MODE_PRI    = 3'd2,
        MODE_SEC    = 3'd3,
        MODE_IDE    = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        CE_NONE    = 2'd0,
        CE_WORD    = 2'd1,
        CE_EVEN_LO = 2'd2,
        CE_ODD_HI  = 2'd3
    } cekind_e;

    localparam logic [IDX_W-1:0] IDX_DATA    = 4'd0;
    localparam logic [IDX_W-1:0] IDX_ERRFEAT = 4'd1;
    localparam logic [IDX_W-1:0] IDX_ALTCTL  = 4'd8;
    localparam logic [IDX_W-1:0] IDX_DRVADR  = 4'd9;

    // Classify the two card enables into an access kind.
    function automatic cekind_e ce_kind(input logic ce1_n, input logic ce2_n);
        case ({ce1_n, ce2_n})
            2'b00:   return CE_WORD;
            2'b01:   return CE_EVEN_LO;
            2'b10:   return CE_ODD_HI;
            default: return CE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ata_strobe_qual.sv
// Qualifies host strobes against the addressing mode.
// Memory mode needs reg_n high with oe_n/we_n; the I/O and disk-drive
// modes need reg_n low with iord_n/iowr_n. A simultaneous read and
// write request is dropped. Purely combinational.
module ata_strobe_qual
    import ata_dec_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              reg_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    output logic              rd_req,
    output logic              wr_req
);
    logic mem_fam;
    logic io_fam;
    logic rd_raw;
    logic wr_raw;

    // Decide which strobe family the mode listens to.
    always_comb begin
        mem_fam = (mode == MODE_MEM);
        io_fam  = (mode == MODE_CONTIG) || (mode == MODE_PRI) ||
                  (mode == MODE_SEC)    || (mode == MODE_IDE);
    end

    // Form read/write requests and drop a conflicting pair.
    always_comb begin
        rd_raw = (mem_fam &&  reg_n && !oe_n) || (io_fam && !reg_n && !iord_n);
        wr_raw = (mem_fam &&  reg_n && !we_n) || (io_fam && !reg_n && !iowr_n);
        rd_req = rd_raw && !wr_raw;
        wr_req = wr_raw && !rd_raw;
    end

endmodule

// File: rtl/ata_io_window.sv
// Matches a 10-bit I/O address against an eight-register block at BASE
// and a two-register control pair at CTRL. The block yields offsets
// 0h-7h and the pair yields Eh-Fh. Assumes BASE is 8-aligned and CTRL
// is even.
module ata_io_window
    import ata_dec_pkg::*;
#(
    parameter int              AW   = 10,
    parameter logic [AW-1:0]   BASE = 10'h1F0,
    parameter logic [AW-1:0]   CTRL = 10'h3F6
) (
    input  logic [AW-1:0]    addr,
    output logic             hit,
    output logic [OFF_W-1:0] raw
);
    logic blk_hit;
    logic ctl_hit;

    // Compare address against both windows and form the offset.
    always_comb begin
        blk_hit = (addr[AW-1:3] == BASE[AW-1:3]);
        ctl_hit = (addr[AW-1:1] == CTRL[AW-1:1]);
        hit     = blk_hit || ctl_hit;
        raw     = blk_hit ? {1'b0, addr[2:0]} : {3'b111, addr[0]};
    end

endmodule

// File: rtl/ata_lane_steer.sv
// Turns a register offset and the card-enable kind into a task-file
// index, a word flag and a high-lane flag. The disk-drive arrangement
// uses its own command/control block split. Combinational; assumes
// raw_ok qualifies raw.
module ata_lane_steer
    import ata_dec_pkg::*;
(
    input  logic             ide_mode,
    input  cekind_e          ce,
    input  logic             raw_ok,
    input  logic [OFF_W-1:0] raw,
    output logic             ok,
    output logic [IDX_W-1:0] idx,
    output logic             word,
    output logic             hi
);
    logic [OFF_W-1:0] eff;
    logic             act;
    logic             map_ok;
    logic             word_t;
    logic             hi_t;
    logic [IDX_W-1:0] map_idx;

    // Steer the offset by card-enable kind outside disk-drive mode.
    always_comb begin
        eff    = raw;
        act    = 1'b1;
        word_t = 1'b0;
        hi_t   = 1'b0;
        case (ce)
            CE_WORD:    begin eff[0] = 1'b0; word_t = 1'b1; end
            CE_EVEN_LO: begin end
            CE_ODD_HI:  begin eff[0] = 1'b1; hi_t = 1'b1; end
            default:    act = 1'b0;
        endcase
    end

    // Map a sixteen-slot offset onto the task-file index.
    always_comb begin
        map_ok  = 1'b1;
        map_idx = IDX_DATA;
        case (eff)
            4'h0, 4'h1, 4'h2, 4'h3,
            4'h4, 4'h5, 4'h6, 4'h7: map_idx = eff;
            4'h8, 4'h9:             map_idx = IDX_DATA;
            4'hD:                   map_idx = IDX_ERRFEAT;
            4'hE:                   map_idx = IDX_ALTCTL;
            4'hF:                   map_idx = IDX_DRVADR;
            default:                map_ok  = 1'b0;
        endcase
    end

    // Pick the final result for the active arrangement.
    always_comb begin
        ok   = 1'b0;
        idx  = IDX_DATA;
        word = 1'b0;
        hi   = 1'b0;
        if (ide_mode) begin
            if (ce == CE_EVEN_LO) begin
                ok   = raw_ok;
                idx  = {1'b0, raw[2:0]};
                word = (raw[2:0] == 3'd0);
            end else if (ce == CE_ODD_HI && raw[2:1] == 2'b11) begin
                ok  = raw_ok;
                idx = raw[0] ? IDX_DRVADR : IDX_ALTCTL;
            end
        end else begin
            ok   = raw_ok && act && map_ok && (!word_t || map_idx == IDX_DATA);
            idx  = map_idx;
            word = word_t;
            hi   = hi_t;
        end
    end

endmodule

// File: rtl/ata_host_decode.sv
// Host address decoder for a removable-card ATA task file. It combines
// strobe qualification, mode windows and byte-lane steering, and
// registers the result. Read/write pulses mark the first cycle of an
// access. Assumes mode_sel is static and ADDR_W >= 10.
module ata_host_decode
    import ata_dec_pkg::*;
#(
    parameter int         ADDR_W   = 11,
    parameter logic [9:0] PRI_BASE = 10'h1F0,
    parameter logic [9:0] PRI_CTRL = 10'h3F6,
    parameter logic [9:0] SEC_BASE = 10'h170,
    parameter logic [9:0] SEC_CTRL = 10'h376
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              reg_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    output logic              tf_sel,
    output logic [IDX_W-1:0]  tf_idx,
    output logic              tf_rd,
    output logic              tf_wr,
    output logic              word_acc,
    output logic              hi_lane,
    output logic              drv_lo_en,
    output logic              drv_hi_en
);
    localparam int IO_AW = 10;
    localparam int N_WIN = 2;
    localparam logic [N_WIN*IO_AW-1:0] WIN_BASES = {SEC_BASE, PRI_BASE};
    localparam logic [N_WIN*IO_AW-1:0] WIN_CTRLS = {SEC_CTRL, PRI_CTRL};

    logic             rd_req;
    logic             wr_req;
    logic [N_WIN-1:0] win_hit;
    logic [OFF_W-1:0] win_raw [N_WIN];
    logic             raw_ok;
    logic [OFF_W-1:0] raw;
    cekind_e          ce_code;
    logic             st_ok;
    logic [IDX_W-1:0] st_idx;
    logic             st_word;
    logic             st_hi;
    logic             hit;
    logic             rd_hit;
    logic             wr_hit;

    logic             sel_q;
    logic [IDX_W-1:0] idx_q;
    logic             word_q;
    logic             hi_q;
    logic             rdact_q;
    logic             wract_q;
    logic             rdp_q;
    logic             wrp_q;

    ata_strobe_qual u_qual (
        .mode   (mode_sel),
        .reg_n  (reg_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .iord_n (iord_n),
        .iowr_n (iowr_n),
        .rd_req (rd_req),
        .wr_req (wr_req)
    );

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        ata_io_window #(
            .AW   (IO_AW),
            .BASE (WIN_BASES[w*IO_AW +: IO_AW]),
            .CTRL (WIN_CTRLS[w*IO_AW +: IO_AW])
        ) u_win (
            .addr (host_addr[IO_AW-1:0]),
            .hit  (win_hit[w]),
            .raw  (win_raw[w])
        );
    end

    // Classify the card enables.
    always_comb ce_code = ce_kind(ce1_n, ce2_n);

    // Select the raw offset source for the active mode.
    always_comb begin
        raw_ok = 1'b0;
        raw    = '0;
        case (mode_sel)
            MODE_MEM, MODE_CONTIG: begin raw_ok = 1'b1; raw = host_addr[OFF_W-1:0]; end
            MODE_PRI:              begin raw_ok = win_hit[0]; raw = win_raw[0]; end
            MODE_SEC:              begin raw_ok = win_hit[1]; raw = win_raw[1]; end
            MODE_IDE:              begin raw_ok = 1'b1; raw = {1'b0, host_addr[2:0]}; end
            default:               begin raw_ok = 1'b0; raw = '0; end
        endcase
    end

    ata_lane_steer u_steer (
        .ide_mode (mode_sel == MODE_IDE),
        .ce       (ce_code),
        .raw_ok   (raw_ok),
        .raw      (raw),
        .ok       (st_ok),
        .idx      (st_idx),
        .word     (st_word),
        .hi       (st_hi)
    );

    // Combine decode with direction; drop writes to the read-only slot.
    always_comb begin
        hit    = st_ok && (rd_req || wr_req) && !(wr_req && st_idx == IDX_DRVADR);
        rd_hit = hit && rd_req;
        wr_hit = hit && wr_req;
    end

    // Register the decoded access and form first-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            idx_q   <= '0;
            word_q  <= 1'b0;
            hi_q    <= 1'b0;
            rdact_q <= 1'b0;
            wract_q <= 1'b0;
            rdp_q   <= 1'b0;
            wrp_q   <= 1'b0;
        end else begin
            sel_q   <= hit;
            idx_q   <= hit ? st_idx : '0;
            word_q  <= hit && st_word;
            hi_q    <= hit && st_hi;
            rdact_q <= rd_hit;
            wract_q <= wr_hit;
            rdp_q   <= rd_hit && !rdact_q;
            wrp_q   <= wr_hit && !wract_q;
        end
    end

    // Drive the outputs, with lane enables only during reads.
    always_comb begin
        tf_sel    = sel_q;
        tf_idx    = idx_q;
        tf_rd     = rdp_q;
        tf_wr     = wrp_q;
        word_acc  = word_q;
        hi_lane   = hi_q;
        drv_lo_en = rdact_q && (word_q || !hi_q);
        drv_hi_en = rdact_q && (word_q || hi_q);
    end

endmodule

// File: rtl/ata_host_decode_chk.sv
// Assertion checker for the host address decoder, bound to the top.
// Relates registered outputs to the inputs of the cycle before.
module ata_host_decode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_sel,
    input logic       ce1_n,
    input logic       ce2_n,
    input logic       oe_n,
    input logic       we_n,
    input logic       iord_n,
    input logic       iowr_n,
    input logic       tf_sel,
    input logic [3:0] tf_idx,
    input logic       tf_rd,
    input logic       tf_wr,
    input logic       word_acc,
    input logic       hi_lane,
    input logic       drv_lo_en,
    input logic       drv_hi_en
);
    // R1
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel > 3'd4) |=> !tf_sel);

    // R2
    word_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_sel && word_acc) |-> (tf_idx == 4'd0 && !hi_lane));

    // R3
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && ce2_n) |=> !tf_sel);

    // R9
    drvadr_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_sel && tf_idx == 4'd9) |-> !tf_wr);

    // R10
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tf_rd |=> !tf_rd);

    // R10
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tf_wr |=> !tf_wr);

    // R10
    wr_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tf_wr |-> !(drv_lo_en || drv_hi_en));

    // R10
    pulse_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_rd || tf_wr) |-> tf_sel);

    // R11
    both_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !we_n && !iord_n && !iowr_n) |=> !tf_sel);

    // R11
    rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tf_rd && tf_wr));
endmodule

bind ata_host_decode ata_host_decode_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .ce1_n     (ce1_n),
    .ce2_n     (ce2_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .iord_n    (iord_n),
    .iowr_n    (iowr_n),
    .tf_sel    (tf_sel),
    .tf_idx    (tf_idx),
    .tf_rd     (tf_rd),
    .tf_wr     (tf_wr),
    .word_acc  (word_acc),
    .hi_lane   (hi_lane),
    .drv_lo_en (drv_lo_en),
    .drv_hi_en (drv_hi_en)
);

// File: tb/ata_host_decode_bench.sv
`timescale 1ns/1ps
module ata_host_decode_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = '0;
    logic [10:0] host_addr = '0;
    logic        ce1_n = 1'b1, ce2_n = 1'b1, reg_n = 1'b1;
    logic        oe_n = 1'b1, we_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
    logic        tf_sel, tf_rd, tf_wr, word_acc, hi_lane, drv_lo_en, drv_hi_en;
    logic [3:0]  tf_idx;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ata_host_decode u_ata_host_decode (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .host_addr(host_addr),
        .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n), .oe_n(oe_n), .we_n(we_n),
        .iord_n(iord_n), .iowr_n(iowr_n), .tf_sel(tf_sel), .tf_idx(tf_idx),
        .tf_rd(tf_rd), .tf_wr(tf_wr), .word_acc(word_acc), .hi_lane(hi_lane),
        .drv_lo_en(drv_lo_en), .drv_hi_en(drv_hi_en)
    );

    // Outputs packed as {sel, rd, wr, word, hi, dlo, dhi, idx[3:0]}.
    function automatic logic [10:0] observed();
        return {tf_sel, tf_rd, tf_wr, word_acc, hi_lane, drv_lo_en, drv_hi_en, tf_idx};
    endfunction

    task automatic bus_idle();
        oe_n = 1'b1; we_n = 1'b1; iord_n = 1'b1; iowr_n = 1'b1;
    endtask

    // Strobe kinds: 0 mem rd, 1 mem wr, 2 io rd, 3 io wr,
    // 4 oe with reg low, 5 iord with reg high, 6 io rd+wr, 7 mem rd+wr.
    task automatic drive_kind(input int k);
        bus_idle();
        case (k)
            0: begin reg_n = 1'b1; oe_n = 1'b0; end
            1: begin reg_n = 1'b1; we_n = 1'b0; end
            2: begin reg_n = 1'b0; iord_n = 1'b0; end
            3: begin reg_n = 1'b0; iowr_n = 1'b0; end
            4: begin reg_n = 1'b0; oe_n = 1'b0; end
            5: begin reg_n = 1'b1; iord_n = 1'b0; end
            6: begin reg_n = 1'b0; iord_n = 1'b0; iowr_n = 1'b0; end
            default: begin reg_n = 1'b1; oe_n = 1'b0; we_n = 1'b0; end
        endcase
    endtask

    function automatic int pick_addr(input int j);
        int lo = j % 16;
        case (j / 16)
            0: return 'h000 + lo;
            1: return 'h1F0 + lo;
            2: return 'h3F0 + lo;
            3: return 'h170 + lo;
            4: return 'h370 + lo;
            5: return 'h5F0 + lo;
            6: return 'h7A0 + lo;
            default: return 'h770 + lo;
        endcase
    endfunction

    // Expected outputs from the requirements; c: 0 word, 1 low, 2 high, 3 none.
    function automatic logic [10:0] model(input int md, input int c, input int a,
                                          input int k, output string tag);
        bit io  = (md >= 1 && md <= 4);
        bit rd  = (md == 0 && (k == 0 || k == 7)) || (io && (k == 2 || k == 6));
        bit wr  = (md == 0 && (k == 1 || k == 7)) || (io && (k == 3 || k == 6));
        int raw = -1;
        int idx = -1;
        int eff;
        bit word = 1'b0;
        bit hi   = 1'b0;
        bit hit;
        logic [10:0] r;
        if (rd && wr) begin rd = 1'b0; wr = 1'b0; end
        if (md <= 1) raw = a % 16;
        else if (md == 2 || md == 3) begin
            int base = (md == 2) ? 'h1F0 : 'h170;
            int a10  = a % 1024;
            if (a10 >= base && a10 < base + 8) raw = a10 - base;
            else if (a10 == base + 'h206) raw = 14;
            else if (a10 == base + 'h207) raw = 15;
        end
        if (md == 4) begin
            int off = a % 8;
            if (c == 1) begin idx = off; word = (off == 0); end
            else if (c == 2) begin
                if (off == 6) idx = 8;
                else if (off == 7) idx = 9;
            end
        end else if (raw >= 0 && c != 3) begin
            eff = raw;
            if (c == 0) begin eff = raw - (raw % 2); word = 1'b1; end
            if (c == 2) begin eff = raw | 1; hi = 1'b1; end
            if (eff < 8) idx = eff;
            else if (eff == 8 || eff == 9) idx = 0;
            else if (eff == 13) idx = 1;
            else if (eff == 14) idx = 8;
            else if (eff == 15) idx = 9;
            if (word && idx != 0) idx = -1;
        end
        if (idx == 9 && wr) idx = -1;
        hit = (idx >= 0) && (rd || wr);
        r = '0;
        if (hit) begin
            r[10]  = 1'b1;
            r[9]   = rd;
            r[8]   = wr;
            r[7]   = word;
            r[6]   = hi;
            r[5]   = rd && (word || !hi);
            r[4]   = rd && (word || hi);
            r[3:0] = 4'(idx);
        end
        if (md > 4 || k == 4 || k == 5)     tag = "R1";
        else if (k >= 6)                    tag = "R11";
        else if (wr && (md == 4 ? (c == 2 && a % 8 == 7) : (raw >= 0 && (raw | 1) == 15 && c != 0)))
                                            tag = "R9";
        else if (md == 4)                   tag = "R8";
        else if (md >= 2)                   tag = "R7";
        else if (c == 0)                    tag = "R2";
        else if (c == 2)                    tag = "R4";
        else if (a > 15)                    tag = "R6";
        else if (c == 1)                    tag = "R5";
        else                                tag = "R3";
        return r;
    endfunction

    task automatic check(input string tag, input logic [10:0] got, input logic [10:0] exp,
                         input string ctx);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%b exp=%b", tag, ctx, got, exp);
        end
    endtask

    initial begin
        #900000;
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog expired got=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        string tag;
        logic [10:0] exp;
        // R12: an active access held during reset leaves outputs at zero.
        @(negedge clk);
        mode_sel = 3'd0; host_addr = 11'h007; ce1_n = 1'b0; ce2_n = 1'b1;
        drive_kind(0);
        repeat (3) @(negedge clk);
        check("R12", observed(), 11'b0, "reset");
        bus_idle(); ce1_n = 1'b1; ce2_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", observed(), 11'b0, "after reset");

        for (int md = 0; md < 8; md++) begin
            for (int k = 0; k < 8; k++) begin
                for (int c = 0; c < 4; c++) begin
                    for (int j = 0; j < 128; j++) begin
                        int a = pick_addr(j);
                        string ctx;
                        exp = model(md, c, a, k, tag);
                        ctx = $sformatf("md=%0d k=%0d ce=%0d addr=%h", md, k, c, a);
                        @(negedge clk);
                        mode_sel  = 3'(md);
                        host_addr = 11'(a);
                        ce1_n     = c[1];
                        ce2_n     = c[0];
                        drive_kind(k);
                        @(negedge clk);
                        check(tag, observed(), exp, ctx);
                        @(negedge clk);
                        // R10: pulses last one cycle, the rest persists.
                        check("R10", observed(), {exp[10], 2'b00, exp[7:0]}, ctx);
                        bus_idle();
                        ce1_n = 1'b1; ce2_n = 1'b1;
                    end
                end
            end
        end
        @(negedge clk);
        check("R10", observed(), 11'b0, "idle");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule